// File: doc/BRIEF.md
# Colour LCD Controller Register Bank

This block is the software-visible register file of a colour LCD controller. A simple bus supplies a byte address inside a 4 KiB window, separate read and write strobes and a 32-bit write value. The block holds four timing words, the base addresses of the upper and lower panel frame buffers, the control word, the interrupt mask and the raw interrupt status. From these it presents the number of active columns and rows, the bits-per-pixel mode and a single flag that is true only when the controller is both enabled and powered. Video timing, pixel fetch and the interrupt sources live elsewhere. The sources reach the status register through the `irq_set` input.

A small access sequencer with five named states handles each bus cycle. `ST_IDLE` is the no-access state. `ST_REG_RD` presents a captured register value. `ST_PAL_RD` forwards the answer of the external palette store. `ST_WR_DONE` marks an accepted write and raises the invalidate pulse. `ST_BAD` marks a rejected access and raises the error pulse. Each cycle the next state is chosen from that cycle's strobes. A write goes to `ST_WR_DONE` if legal and to `ST_BAD` otherwise. A read without a write goes to `ST_BAD` if illegal, to `ST_PAL_RD` inside the palette window and to `ST_REG_RD` otherwise. No strobe returns the sequencer to `ST_IDLE`. Every state lasts one cycle.

A strap input selects an alternate variant in which the mask and control slots trade addresses. A 128-word palette window is passed through to a separate palette block. Eight fixed identification bytes sit at the top of the window.

Top module: `lcdc_regbank`

## Requirements
- R1: After reset every stored register, the derived column and row counts, `bus_rdata`, `bus_err`, `invalidate` and `irq_out` are zero.
- R2: Word index is `bus_addr[11:2]`, and the two low address bits are ignored. Words 0 to 3 are the timing registers and word 4 and word 5 the upper and lower base. Each reads back its last written value on `bus_rdata` in the cycle after the read strobe. Outside that cycle `bus_rdata` is zero.
- R3: With `variant_sel` low, word 6 is the interrupt mask and word 7 the control word. With it high the two swap for both reads and writes.
- R4: `bpp_mode` equals control bits [3:1]. `lcd_on` is high only when control bit 0 and control bit 11 are both set.
- R5: A write to word 0 sets `active_cols` to ((value & 0xFC) + 4) * 4.
- R6: A write to word 1 sets `active_rows` to (value & 0x3FF) + 1.
- R7: Each set bit of `irq_set` sets the matching raw status bit. Word 8 reads raw status, and word 9 reads raw status AND mask. `irq_out` is the OR of the masked status bits.
- R8: Writing word 10 clears the raw status bits that are 1 in the value. A bit set by `irq_set` in the same cycle stays set.
- R9: Words 11 and 12 read the upper and lower base address.
- R10: Words 0x3F8 to 0x3FF read one identification byte each, in the order 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, zero-extended.
- R11: Words 0x80 to 0xFF are the palette window. Accesses there strobe `pal_wr` or `pal_rd` in the same cycle with `pal_idx` = `bus_addr[8:2]` and `pal_wdata` = `bus_wdata`. A palette read returns `pal_rdata` on `bus_rdata` in the following cycle.
- R12: Every accepted register or palette write, including word 10, raises `invalidate` for exactly the following cycle.
- R13: Some accesses are rejected: an undefined word, a read of word 10, or a write to words 8, 9, 11, 12 or the identification words. A rejected read returns zero, and a rejected write changes no state. Either one raises `bus_err` for the following cycle. When both strobes are high the write is performed and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| variant_sel | input | 1 | Strap: swap mask and control slots |
| bus_addr | input | 12 | Byte address within the window |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write value |
| bus_rdata | output | 32 | Read value, valid the cycle after the read strobe |
| bus_err | output | 1 | Rejected-access pulse |
| invalidate | output | 1 | Accepted-write pulse |
| pal_rd | output | 1 | Palette read strobe |
| pal_wr | output | 1 | Palette write strobe |
| pal_idx | output | 7 | Palette entry index |
| pal_wdata | output | 32 | Palette write value |
| pal_rdata | input | 32 | Palette read value, one cycle after `pal_rd` |
| irq_set | input | 5 | Interrupt source set pulses |
| irq_out | output | 1 | Interrupt request |
| upper_base | output | 32 | Upper panel frame base |
| lower_base | output | 32 | Lower panel frame base |
| ctrl_word | output | 32 | Control word |
| bpp_mode | output | 3 | Bits-per-pixel mode |
| lcd_on | output | 1 | Enabled and powered |
| active_cols | output | 11 | Active column count |
| active_rows | output | 11 | Active row count |

## Verification
The bench targets the geometry extremes. Field values 0xFF and 0 for columns, and 0x3FF and values with only high bits set for rows, catch a formula that drops the +4 or +1 or masks the wrong bits. With the strap toggled it writes and reads words 6 and 7: a design that swaps on only one direction would show the mask in the control output. Set and clear arrive together on one status bit, which a clear-wins design would lose. Random mixes of rejected accesses, simultaneous strobes and palette traffic expose stale read data, errors that leak into invalidate, and writes that corrupt state they should not touch.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

    // Register slot chosen by the address decoder (after the variant swap)
    typedef enum logic [4:0] {
        SL_NONE,
        SL_TIM0,
        SL_TIM1,
        SL_TIM2,
        SL_TIM3,
        SL_UPBASE,
        SL_LPBASE,
        SL_MASK,
        SL_CTRL,
        SL_RAW,
        SL_MSTAT,
        SL_CLEAR,
        SL_UPCUR,
        SL_LPCUR,
        SL_ID,
        SL_PAL
    } slot_e;

    // Bus access sequencer states, one cycle each
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REG_RD,
        ST_PAL_RD,
        ST_WR_DONE,
        ST_BAD
    } acc_state_e;

    localparam int N_TIMING = 4;

    function automatic slot_e timing_slot(input int k);
        slot_e s;
        case (k)
            0:       s = SL_TIM0;
            1:       s = SL_TIM1;
            2:       s = SL_TIM2;
            default: s = SL_TIM3;
        endcase
        return s;
    endfunction

    // Identification byte for word k of the ID block
    function automatic logic [7:0] id_byte(input logic [2:0] k);
        logic [7:0] b;
        case (k)
            3'd0:    b = 8'h10;
            3'd1:    b = 8'h11;
            3'd2:    b = 8'h04;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/lcdc_decode.sv
module lcdc_decode
    import lcdc_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int PAL_IDX_W = 7
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 variant,
    output slot_e                slot,
    output logic                 rd_legal,
    output logic                 wr_legal,
    output logic [PAL_IDX_W-1:0] pal_idx
);
    localparam int WORD_W   = ADDR_W - 2;
    localparam int PAL_LO   = 1 << PAL_IDX_W;
    localparam int PAL_HI   = 2 * PAL_LO - 1;
    localparam int ID_FIRST = (1 << WORD_W) - 8;

    logic [WORD_W-1:0] word;
    int                word_i;

    assign word    = addr[ADDR_W-1:2];
    assign word_i  = int'(word);
    assign pal_idx = word[PAL_IDX_W-1:0];

    always_comb begin
        slot = SL_NONE;
        if (word_i >= ID_FIRST) begin
            slot = SL_ID;
        end else if (word_i >= PAL_LO && word_i <= PAL_HI) begin
            slot = SL_PAL;
        end else begin
            case (word_i)
                0:       slot = SL_TIM0;
                1:       slot = SL_TIM1;
                2:       slot = SL_TIM2;
                3:       slot = SL_TIM3;
                4:       slot = SL_UPBASE;
                5:       slot = SL_LPBASE;
                6:       slot = variant ? SL_CTRL : SL_MASK;
                7:       slot = variant ? SL_MASK : SL_CTRL;
                8:       slot = SL_RAW;
                9:       slot = SL_MSTAT;
                10:      slot = SL_CLEAR;
                11:      slot = SL_UPCUR;
                12:      slot = SL_LPCUR;
                default: slot = SL_NONE;
            endcase
        end
    end

    always_comb begin
        rd_legal = (slot != SL_NONE) && (slot != SL_CLEAR);
        case (slot)
            SL_TIM0, SL_TIM1, SL_TIM2, SL_TIM3,
            SL_UPBASE, SL_LPBASE, SL_MASK, SL_CTRL,
            SL_CLEAR, SL_PAL: wr_legal = 1'b1;
            default:          wr_legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/lcdc_access_fsm.sv
module lcdc_access_fsm
    import lcdc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_rd,
    input  logic bus_wr,
    input  logic rd_legal,
    input  logic wr_legal,
    input  logic is_pal,
    output logic reg_wr_en,
    output logic pal_wr,
    output logic pal_rd,
    output logic capture,
    output logic sel_reg,
    output logic sel_pal,
    output logic invalidate,
    output logic bus_err
);
    acc_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: write has priority over a simultaneous read
    always_comb begin
        if (bus_wr) begin
            state_d = wr_legal ? ST_WR_DONE : ST_BAD;
        end else if (bus_rd) begin
            if (!rd_legal)   state_d = ST_BAD;
            else if (is_pal) state_d = ST_PAL_RD;
            else             state_d = ST_REG_RD;
        end else begin
            state_d = ST_IDLE;
        end
    end

    // Outputs
    always_comb begin
        reg_wr_en  = bus_wr && wr_legal && !is_pal;
        pal_wr     = bus_wr && wr_legal && is_pal;
        pal_rd     = !bus_wr && bus_rd && rd_legal && is_pal;
        capture    = !bus_wr && bus_rd && rd_legal && !is_pal;
        sel_reg    = 1'b0;
        sel_pal    = 1'b0;
        invalidate = 1'b0;
        bus_err    = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_REG_RD:  sel_reg    = 1'b1;
            ST_PAL_RD:  sel_pal    = 1'b1;
            ST_WR_DONE: invalidate = 1'b1;
            ST_BAD:     bus_err    = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/lcdc_regs.sv
module lcdc_regs
    import lcdc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IRQ_W  = 5,
    parameter int COL_W  = 11,
    parameter int ROW_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  slot_e             slot,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IRQ_W-1:0]  irq_set,
    output logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] upper_base,
    output logic [DATA_W-1:0] lower_base,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [2:0]        bpp_mode,
    output logic              lcd_on,
    output logic [COL_W-1:0]  active_cols,
    output logic [ROW_W-1:0]  active_rows,
    output logic              irq_out
);
    localparam int EN_BIT  = 0;
    localparam int PWR_BIT = 11;
    localparam int HF_W    = 6;   // column field width, bits [7:2]
    localparam int VF_W    = 10;  // row field width, bits [9:0]

    logic [DATA_W-1:0] timing_q [N_TIMING];
    logic [DATA_W-1:0] upb_q, lpb_q, mask_q, ctrl_q;
    logic [IRQ_W-1:0]  raw_q;
    logic [COL_W-1:0]  cols_q;
    logic [ROW_W-1:0]  rows_q;
    logic [HF_W:0]     col_units;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N_TIMING; k++) timing_q[k] <= '0;
        end else if (wr_en) begin
            for (int k = 0; k < N_TIMING; k++)
                if (slot == timing_slot(k)) timing_q[k] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upb_q  <= '0;
            lpb_q  <= '0;
            mask_q <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            if (slot == SL_UPBASE) upb_q  <= wdata;
            if (slot == SL_LPBASE) lpb_q  <= wdata;
            if (slot == SL_MASK)   mask_q <= wdata;
            if (slot == SL_CTRL)   ctrl_q <= wdata;
        end
    end

    // Geometry: columns = (field + 1) * 16, rows = field + 1
    assign col_units = {1'b0, wdata[7:2]} + {{HF_W{1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cols_q <= '0;
            rows_q <= '0;
        end else if (wr_en) begin
            if (slot == SL_TIM0) cols_q <= COL_W'({col_units, 4'b0000});
            if (slot == SL_TIM1) rows_q <= ROW_W'({1'b0, wdata[VF_W-1:0]}) + ROW_W'(1);
        end
    end

    // Raw status: set sources win over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else if (wr_en && slot == SL_CLEAR) begin
            raw_q <= (raw_q & ~wdata[IRQ_W-1:0]) | irq_set;
        end else begin
            raw_q <= raw_q | irq_set;
        end
    end

    always_comb begin
        rd_word = '0;
        case (slot)
            SL_TIM0:              rd_word = timing_q[0];
            SL_TIM1:              rd_word = timing_q[1];
            SL_TIM2:              rd_word = timing_q[2];
            SL_TIM3:              rd_word = timing_q[3];
            SL_UPBASE, SL_UPCUR:  rd_word = upb_q;
            SL_LPBASE, SL_LPCUR:  rd_word = lpb_q;
            SL_MASK:              rd_word = mask_q;
            SL_CTRL:              rd_word = ctrl_q;
            SL_RAW:               rd_word[IRQ_W-1:0] = raw_q;
            SL_MSTAT:             rd_word[IRQ_W-1:0] = raw_q & mask_q[IRQ_W-1:0];
            default:              rd_word = '0;
        endcase
    end

    assign upper_base  = upb_q;
    assign lower_base  = lpb_q;
    assign ctrl_word   = ctrl_q;
    assign bpp_mode    = ctrl_q[3:1];
    assign lcd_on      = ctrl_q[EN_BIT] & ctrl_q[PWR_BIT];
    assign active_cols = cols_q;
    assign active_rows = rows_q;
    assign irq_out     = |(raw_q & mask_q[IRQ_W-1:0]);

endmodule

// File: rtl/lcdc_regbank.sv
module lcdc_regbank
    import lcdc_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 12,
    parameter int IRQ_W     = 5,
    parameter int PAL_IDX_W = 7,
    parameter int COL_W     = 11,
    parameter int ROW_W     = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 variant_sel,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 bus_err,
    output logic                 invalidate,
    output logic                 pal_rd,
    output logic                 pal_wr,
    output logic [PAL_IDX_W-1:0] pal_idx,
    output logic [DATA_W-1:0]    pal_wdata,
    input  logic [DATA_W-1:0]    pal_rdata,
    input  logic [IRQ_W-1:0]     irq_set,
    output logic                 irq_out,
    output logic [DATA_W-1:0]    upper_base,
    output logic [DATA_W-1:0]    lower_base,
    output logic [DATA_W-1:0]    ctrl_word,
    output logic [2:0]           bpp_mode,
    output logic                 lcd_on,
    output logic [COL_W-1:0]     active_cols,
    output logic [ROW_W-1:0]     active_rows
);
    slot_e             slot;
    logic              rd_legal, wr_legal;
    logic              reg_wr_en, capture, sel_reg, sel_pal;
    logic [DATA_W-1:0] reg_word, rd_mux, rd_hold;

    lcdc_decode #(
        .ADDR_W    (ADDR_W),
        .PAL_IDX_W (PAL_IDX_W)
    ) u_decode (
        .addr     (bus_addr),
        .variant  (variant_sel),
        .slot     (slot),
        .rd_legal (rd_legal),
        .wr_legal (wr_legal),
        .pal_idx  (pal_idx)
    );

    lcdc_access_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .rd_legal   (rd_legal),
        .wr_legal   (wr_legal),
        .is_pal     (slot == SL_PAL),
        .reg_wr_en  (reg_wr_en),
        .pal_wr     (pal_wr),
        .pal_rd     (pal_rd),
        .capture    (capture),
        .sel_reg    (sel_reg),
        .sel_pal    (sel_pal),
        .invalidate (invalidate),
        .bus_err    (bus_err)
    );

    lcdc_regs #(
        .DATA_W (DATA_W),
        .IRQ_W  (IRQ_W),
        .COL_W  (COL_W),
        .ROW_W  (ROW_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr_en),
        .slot        (slot),
        .wdata       (bus_wdata),
        .irq_set     (irq_set),
        .rd_word     (reg_word),
        .upper_base  (upper_base),
        .lower_base  (lower_base),
        .ctrl_word   (ctrl_word),
        .bpp_mode    (bpp_mode),
        .lcd_on      (lcd_on),
        .active_cols (active_cols),
        .active_rows (active_rows),
        .irq_out     (irq_out)
    );

    assign rd_mux = (slot == SL_ID) ? DATA_W'(id_byte(bus_addr[4:2])) : reg_word;

    always_ff @(posedge clk) begin
        if (!rst_n)       rd_hold <= '0;
        else if (capture) rd_hold <= rd_mux;
    end

    assign pal_wdata = bus_wdata;
    assign bus_rdata = sel_reg ? rd_hold : (sel_pal ? pal_rdata : '0);

endmodule

// File: rtl/lcdc_regbank_chk.sv
module lcdc_regbank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [11:0] bus_addr,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [31:0] bus_rdata,
    input logic        bus_err,
    input logic        invalidate,
    input logic        pal_wr,
    input logic [4:0]  irq_set,
    input logic        irq_out,
    input logic        lcd_on,
    input logic [10:0] active_cols,
    input logic [10:0] active_rows
);
    // R5
    cols_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_cols) |-> $past(bus_wr) && ($past(bus_addr[11:2]) == 10'd0));

    // R6
    rows_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_rows) |-> $past(bus_wr) && ($past(bus_addr[11:2]) == 10'd1));

    // R4
    enable_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lcd_on) |-> $past(bus_wr));

    // R7
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> ($past(|irq_set) || $past(bus_wr)));

    // R11
    pal_write_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pal_wr |=> invalidate);

    // R12
    inval_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        invalidate |-> $past(bus_wr));

    // R13
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({invalidate, bus_err}));

    // R13
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_rd || bus_wr));

    // R2
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> (bus_rdata == 32'd0));

endmodule

bind lcdc_regbank lcdc_regbank_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_rdata   (bus_rdata),
    .bus_err     (bus_err),
    .invalidate  (invalidate),
    .pal_wr      (pal_wr),
    .irq_set     (irq_set),
    .irq_out     (irq_out),
    .lcd_on      (lcd_on),
    .active_cols (active_cols),
    .active_rows (active_rows)
);

// File: tb/tb_lcdc_regbank.sv
module tb_lcdc_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        variant_sel = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err, invalidate, pal_rd, pal_wr, irq_out, lcd_on;
    logic [6:0]  pal_idx;
    logic [31:0] pal_wdata;
    logic [31:0] pal_rdata = '0;
    logic [4:0]  irq_set = '0;
    logic [31:0] upper_base, lower_base, ctrl_word;
    logic [2:0]  bpp_mode;
    logic [10:0] active_cols, active_rows;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    lcdc_regbank dut (
        .clk(clk), .rst_n(rst_n), .variant_sel(variant_sel),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .invalidate(invalidate), .pal_rd(pal_rd), .pal_wr(pal_wr),
        .pal_idx(pal_idx), .pal_wdata(pal_wdata), .pal_rdata(pal_rdata),
        .irq_set(irq_set), .irq_out(irq_out), .upper_base(upper_base),
        .lower_base(lower_base), .ctrl_word(ctrl_word), .bpp_mode(bpp_mode),
        .lcd_on(lcd_on), .active_cols(active_cols), .active_rows(active_rows)
    );

    // Palette store fixture: one-cycle read latency
    logic [31:0] pal_mem [128];
    initial for (int i = 0; i < 128; i++) pal_mem[i] = '0;
    always_ff @(posedge clk) begin
        if (pal_rd) pal_rdata <= pal_mem[pal_idx];
        if (pal_wr) pal_mem[pal_idx] <= pal_wdata;
    end

    // Reference model
    logic [31:0] m_tim [4];
    logic [31:0] m_up, m_lo, m_mask, m_ctrl;
    logic [4:0]  m_raw;
    int          m_cols, m_rows;
    logic [31:0] m_pal [128];

    task automatic model_reset();
        for (int i = 0; i < 4; i++) m_tim[i] = '0;
        for (int i = 0; i < 128; i++) m_pal[i] = '0;
        m_up = '0; m_lo = '0; m_mask = '0; m_ctrl = '0; m_raw = '0;
        m_cols = 0; m_rows = 0;
    endtask

    // Slot codes: 0-5 timing/base, 6 mask, 7 ctrl, 8 raw, 9 masked, 10 clear,
    // 11/12 current, 20 id, 21 palette, -1 undefined
    function automatic int b_slot(input int word, input bit var_s);
        if (word >= 'h3F8) return 20;
        if (word >= 'h80 && word <= 'hFF) return 21;
        if (word == 6) return var_s ? 7 : 6;
        if (word == 7) return var_s ? 6 : 7;
        if (word <= 12) return word;
        return -1;
    endfunction

    function automatic logic [7:0] b_id(input int k);
        logic [7:0] t [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        return t[k];
    endfunction

    function automatic bit b_rd_ok(input int s);
        return (s != -1) && (s != 10);
    endfunction

    function automatic bit b_wr_ok(input int s);
        return (s >= 0 && s <= 7) || s == 10 || s == 21;
    endfunction

    function automatic logic [31:0] b_read(input int s, input int word);
        case (s)
            0, 1, 2, 3: return m_tim[s];
            4, 11:      return m_up;
            5, 12:      return m_lo;
            6:          return m_mask;
            7:          return m_ctrl;
            8:          return {27'd0, m_raw};
            9:          return {27'd0, m_raw & m_mask[4:0]};
            20:         return {24'd0, b_id(word - 'h3F8)};
            21:         return m_pal[word - 'h80];
            default:    return '0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic check_outputs();
        check("R5 active_cols", 32'(active_cols), 32'(m_cols));
        check("R6 active_rows", 32'(active_rows), 32'(m_rows));
        check("R4 bpp_mode", 32'(bpp_mode), 32'(m_ctrl[3:1]));
        check("R4 lcd_on", 32'(lcd_on), 32'(m_ctrl[0] & m_ctrl[11]));
        check("R7 irq_out", 32'(irq_out), 32'(|(m_raw & m_mask[4:0])));
        check("R2 upper_base", upper_base, m_up);
        check("R3 ctrl_word", ctrl_word, m_ctrl);
    endtask

    // kind: 0 idle, 1 read, 2 write, 3 read+write
    task automatic do_op(input int kind, input int word, input logic [31:0] data,
                         input logic [4:0] set, input string req);
        int s;
        bit rd, wr, rd_ok, wr_ok;
        logic [31:0] exp_rd;
        rd = (kind == 1) || (kind == 3);
        wr = (kind == 2) || (kind == 3);
        s = b_slot(word, variant_sel);
        rd_ok = b_rd_ok(s);
        wr_ok = b_wr_ok(s);
        exp_rd = (rd && !wr && rd_ok) ? b_read(s, word) : '0;
        @(negedge clk);
        bus_addr  = 12'((word << 2) | int'($urandom_range(0, 3)));
        bus_rd    = rd;
        bus_wr    = wr;
        bus_wdata = data;
        irq_set   = set;
        @(negedge clk);
        bus_rd  = 1'b0;
        bus_wr  = 1'b0;
        irq_set = '0;
        check({req, " rdata"}, bus_rdata, exp_rd);
        check("R13 bus_err", 32'(bus_err), 32'((wr && !wr_ok) || (rd && !wr && !rd_ok)));
        check("R12 invalidate", 32'(invalidate), 32'(wr && wr_ok));
        if (wr && wr_ok) begin
            case (s)
                0: begin m_tim[0] = data; m_cols = ((int'(data) & 'hFC) + 4) * 4; end
                1: begin m_tim[1] = data; m_rows = (int'(data) & 'h3FF) + 1; end
                2, 3: m_tim[s] = data;
                4: m_up = data;
                5: m_lo = data;
                6: m_mask = data;
                7: m_ctrl = data;
                10: m_raw = m_raw & ~data[4:0];
                21: m_pal[word - 'h80] = data;
                default: ;
            endcase
        end
        m_raw = m_raw | set;
        check_outputs();
    endtask

    function automatic int rand_word();
        int c;
        c = int'($urandom_range(0, 9));
        if (c <= 4) return int'($urandom_range(0, 12));
        if (c == 5) return int'($urandom_range('h3F8, 'h3FF));
        if (c <= 7) return int'($urandom_range('h80, 'hFF));
        if (c == 8) return int'($urandom_range(13, 'h7F));
        return int'($urandom_range('h100, 'h3F7));
    endfunction

    task automatic random_phase(input int n);
        for (int i = 0; i < n; i++) begin
            int kind;
            logic [4:0] set;
            kind = int'($urandom_range(0, 9));
            kind = (kind < 4) ? 1 : (kind < 8) ? 2 : (kind == 8) ? 3 : 0;
            set  = ($urandom_range(0, 5) == 0) ? 5'($urandom) : 5'd0;
            do_op(kind, rand_word(), $urandom, set, "R2 random");
        end
    endtask

    initial begin
        #2_000_000;
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", bus_rdata, '0);
        check("R1 bus_err", 32'(bus_err), 0);
        check("R1 invalidate", 32'(invalidate), 0);
        check_outputs();
        do_op(1, 0, '0, '0, "R1 timing0 reads zero");

        // R5 / R6 geometry extremes
        do_op(2, 0, 32'h0000_00FF, '0, "R5");
        do_op(2, 0, 32'hFFFF_FF03, '0, "R5");
        do_op(2, 1, 32'h0000_03FF, '0, "R6");
        do_op(2, 1, 32'hFFFF_FC00, '0, "R6");
        do_op(1, 1, '0, '0, "R2 timing1 readback");

        // R4 enable needs both bits
        do_op(2, 7, 32'h0000_0001, '0, "R4");
        do_op(2, 7, 32'h0000_080B, '0, "R4");
        // R10 identification bytes
        for (int k = 0; k < 8; k++) do_op(1, 'h3F8 + k, '0, '0, "R10");
        // R9 current-address words
        do_op(2, 4, 32'h8000_1000, '0, "R9");
        do_op(2, 5, 32'h0004_2000, '0, "R9");
        do_op(1, 11, '0, '0, "R9");
        do_op(1, 12, '0, '0, "R9");
        // R7 / R8 status: set wins over clear in the same cycle
        do_op(2, 6, 32'h0000_0005, '0, "R7 mask");
        do_op(0, 0, '0, 5'b00111, "R7 set");
        do_op(1, 8, '0, '0, "R7 raw");
        do_op(1, 9, '0, '0, "R7 masked");
        do_op(2, 10, 32'h0000_0003, 5'b00001, "R8 clear vs set");
        do_op(1, 8, '0, '0, "R8 raw after clear");
        do_op(1, 10, '0, '0, "R13 read of clear word");
        do_op(2, 8, 32'hFFFF_FFFF, '0, "R13 write read-only");
        do_op(2, 'h40, 32'h1234_5678, '0, "R13 undefined write");
        do_op(1, 'h40, '0, '0, "R13 undefined read");
        // R11 palette
        do_op(2, 'h85, 32'hCAFE_0001, '0, "R11");
        do_op(1, 'h85, '0, '0, "R11");
        do_op(3, 'h85, 32'h0BAD_0002, '0, "R13 write wins");
        do_op(1, 'h85, '0, '0, "R11");

        random_phase(400);

        // R3 variant: slots 6 and 7 swap
        variant_sel = 1'b1;
        do_op(2, 6, 32'h0000_0801, '0, "R3 ctrl at word 6");
        do_op(2, 7, 32'h0000_001F, '0, "R3 mask at word 7");
        do_op(1, 6, '0, '0, "R3");
        do_op(1, 7, '0, '0, "R3");
        random_phase(300);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule